// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources next to a small CPU core, filters them through a global gate and a per-source mask, and places each source on one of two priority levels. Whenever a request may be taken, it raises a request line and presents the entry address of the winning source. When the core takes a vector, the block records the level as in service. A return strobe releases the most important level that is still active.

There are two external pins, both active low. Each one can be level-sensed or edge-latched. The two timer overflow pulses are latched inside the block, and the block clears these latches when their vector is taken. The serial and timer-2 sources each combine two flags that are held outside the block. Clearing those flags is the job of the software, so the block never touches them.

A wake line reports any pending request that is both gated and masked on, so that power-saving logic can resume the clock. Software programs the mask and level registers through a byte-wide port with a one-bit register select.

Top module: `intc_two_level`

## Requirements
- R1: After reset, both configuration registers read 0x40, and irq_req, wake and isr_level are all 0.
- R2: Bit 6 of either register always reads 1, whatever value was written to it. All other bits read back as written. With cfg_sel=0 the port reaches the mask register: bit 7 is the global gate and bits 5..0 are the per-source masks. With cfg_sel=1 it reaches the level register: bit 7 is the flat-mode bit and bits 5..0 are the per-source high-level bits.
- R3: Source indices are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, tmr2=5. The bit for each source in both registers is its index. The vector is 0x0003 + 8*index.
- R4: While the global gate is 0, irq_req and wake stay 0. While the gate is 1, a source can request only if its own mask bit is 1.
- R5: In normal mode, any high-level request wins over every low-level request, whatever their indices.
- R6: While the flat-mode bit is 1, the level bits are ignored. All sources count as low level, and one request in service blocks every other request.
- R7: Among eligible requests on the same level, the lowest index wins.
- R8: With its edge bit at 0, an external source requests while its pin is low, one clock after the pin is sampled. It stops requesting one clock after the pin returns high, and nothing is latched.
- R9: With its edge bit at 1, a falling edge on an external pin latches a request. The latch stays set after the pin goes high again. It is cleared when that source's vector is taken.
- R10: A timer overflow pulse latches a request, and the latch is cleared when that timer's vector is taken. If a pulse arrives in the same cycle as the take, the pulse wins and the latch stays set. The serial request (rx OR tx) and the timer-2 request (overflow OR external) are never cleared by the block.
- R11: While a low-level service is active, only high-level requests are offered. While a high-level service is active, no request is offered.
- R12: irq_return clears the high in-service bit if it is set. Otherwise it clears the low in-service bit. isr_level bit 1 is the high level and bit 0 is the low level.
- R13: wake is 1 whenever any gated, masked request is pending, even while an active service blocks irq_req.
- R14: src_ack is one-hot on the offered source during a cycle with vec_take and irq_req both high. At all other times src_ack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = mask register, 1 = level register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected register |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per-pin 1 = edge latch, 0 = level sense |
| tmr_ovf | input | 2 | Timer 0/1 overflow pulses |
| ser_rx_done | input | 1 | Serial receive flag |
| ser_tx_done | input | 1 | Serial transmit flag |
| t2_ovf | input | 1 | Timer 2 overflow flag |
| t2_ext | input | 1 | Timer 2 external trigger flag |
| vec_take | input | 1 | Core takes the offered vector |
| irq_return | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | A vector is offered |
| irq_vector | output | 16 | Entry address of the offered source |
| src_ack | output | 6 | One-hot acknowledge of the taken source |
| isr_level | output | 2 | In-service levels, bit 1 high, bit 0 low |
| wake | output | 1 | Enabled request pending |

## Verification
The risky coincidence is a timer overflow pulse landing in the same cycle that the core takes that timer's vector. In that cycle the latch sees a set and a clear at once. The bench drives tmr_ovf together with vec_take and then releases the service with irq_return. It judges the result by whether the same timer vector is offered again. It also makes a preempting high-level take while a low-level service is active, and checks that the two returns unwind the levels in high-then-low order.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC       = 6;
    localparam int IDXW       = $clog2(NSRC);
    localparam int VECW       = 16;
    localparam int REGW       = 8;
    localparam int NEXT       = 2;
    localparam int NTMR       = 2;
    localparam int RESV_BIT   = 6;
    localparam int TOP_BIT    = 7;
    localparam logic [VECW-1:0] VEC_BASE   = 16'h0003;
    localparam int              VEC_SHIFT  = 3;

    typedef enum logic [IDXW-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef struct packed {
        logic            gate;
        logic [NSRC-1:0] mask;
    } en_cfg_t;

    typedef struct packed {
        logic            flat;
        logic [NSRC-1:0] high;
    } pri_cfg_t;

    typedef struct packed {
        logic            valid;
        logic            level;
        logic [IDXW-1:0] idx;
    } pick_t;

    function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_BASE + (VECW'(idx) << VEC_SHIFT);
    endfunction

    function automatic logic [NSRC-1:0] onehot_of(input logic [IDXW-1:0] idx);
        return NSRC'(1) << idx;
    endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            sel,
    input  logic [REGW-1:0] wdata,
    output en_cfg_t         en_o,
    output pri_cfg_t        pri_o,
    output logic [REGW-1:0] rdata
);
    en_cfg_t  en_q;
    pri_cfg_t pri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
        end else if (wr) begin
            if (!sel) begin
                en_q.gate <= wdata[TOP_BIT];
                en_q.mask <= wdata[NSRC-1:0];
            end else begin
                pri_q.flat <= wdata[TOP_BIT];
                pri_q.high <= wdata[NSRC-1:0];
            end
        end
    end

    always_comb begin
        if (sel) rdata = {pri_q.flat, 1'b1, pri_q.high};
        else     rdata = {en_q.gate,  1'b1, en_q.mask};
    end

    assign en_o  = en_q;
    assign pri_o = pri_q;

    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        (wr && !sel) |=> (en_q.gate == $past(wdata[TOP_BIT]) && en_q.mask == $past(wdata[NSRC-1:0])));
    a_r2_level_write: assert property (@(posedge clk) disable iff (rst)
        (wr && sel) |=> (pri_q.flat == $past(wdata[TOP_BIT])));
endmodule

// File: rtl/intc_req.sv
module intc_req
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [NTMR-1:0] tmr_ovf,
    input  logic            ser_rx,
    input  logic            ser_tx,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic [NSRC-1:0] taken,
    output logic [NSRC-1:0] req
);
    logic [NEXT-1:0] s1_q, s2_q, eflag_q, ext_req;
    logic [NTMR-1:0] tflag_q;

    localparam int EXT_IDX [NEXT] = '{int'(SRC_EXT0), int'(SRC_EXT1)};
    localparam int TMR_IDX [NTMR] = '{int'(SRC_TMR0), int'(SRC_TMR1)};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= ext_n;
            s2_q <= s1_q;
        end
    end

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        logic fall;
        assign fall = s2_q[g] & ~s1_q[g];
        always_ff @(posedge clk) begin
            if (rst || !ext_edge[g]) eflag_q[g] <= 1'b0;
            else eflag_q[g] <= (eflag_q[g] & ~taken[EXT_IDX[g]]) | fall;
        end
        assign ext_req[g] = ext_edge[g] ? eflag_q[g] : ~s1_q[g];

        a_r9_edge_latch: assert property (@(posedge clk) disable iff (rst)
            (ext_edge[g] && fall) |=> eflag_q[g]);
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst) tflag_q[g] <= 1'b0;
            else tflag_q[g] <= (tflag_q[g] & ~taken[TMR_IDX[g]]) | tmr_ovf[g];
        end

        a_r10_tmr_clear: assert property (@(posedge clk) disable iff (rst)
            (taken[TMR_IDX[g]] && !tmr_ovf[g]) |=> !tflag_q[g]);
        a_r10_tmr_set_wins: assert property (@(posedge clk) disable iff (rst)
            tmr_ovf[g] |=> tflag_q[g]);
    end

    always_comb begin
        req = '0;
        req[SRC_EXT0] = ext_req[0];
        req[SRC_TMR0] = tflag_q[0];
        req[SRC_EXT1] = ext_req[1];
        req[SRC_TMR1] = tflag_q[1];
        req[SRC_SER]  = ser_rx | ser_tx;
        req[SRC_TMR2] = t2_ovf | t2_ext;
    end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  en_cfg_t         en,
    input  pri_cfg_t        pri,
    input  logic            take,
    input  logic            ret,
    output logic            irq,
    output logic [VECW-1:0] vector,
    output logic [NSRC-1:0] src_ack,
    output logic [1:0]      isr,
    output logic            wake
);
    logic [NSRC-1:0] live, high_eff, hi_set, lo_set;
    pick_t           pick;
    logic [1:0]      isr_q, isr_d;
    logic            taken;

    assign live     = req & en.mask & {NSRC{en.gate}};
    assign high_eff = pri.flat ? '0 : pri.high;
    assign hi_set   = live & high_eff;
    assign lo_set   = live & ~high_eff;

    always_comb begin
        pick = '0;
        if (!isr_q[1] && |hi_set) begin
            pick.valid = 1'b1;
            pick.level = 1'b1;
            pick.idx   = first_set(hi_set);
        end else if (isr_q == 2'b00 && |lo_set) begin
            pick.valid = 1'b1;
            pick.level = 1'b0;
            pick.idx   = first_set(lo_set);
        end
    end

    assign taken   = take & pick.valid;
    assign irq     = pick.valid;
    assign vector  = pick.valid ? vec_of(pick.idx) : '0;
    assign src_ack = taken ? onehot_of(pick.idx) : '0;
    assign wake    = |live;

    always_comb begin
        isr_d = isr_q;
        if (ret) begin
            if (isr_d[1]) isr_d[1] = 1'b0;
            else          isr_d[0] = 1'b0;
        end
        if (taken) isr_d[pick.level] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_d;
    end

    assign isr = isr_q;

    a_r14_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ack));
    a_r14_ack_needs_take: assert property (@(posedge clk) disable iff (rst)
        (src_ack != '0) |-> (take && irq));
    a_r11_take_marks_level: assert property (@(posedge clk) disable iff (rst)
        (taken && pick.level) |=> isr_q[1]);
    a_r12_ret_drops_high: assert property (@(posedge clk) disable iff (rst)
        (ret && isr_q[1] && !take) |=> (!isr_q[1] && isr_q[0] == $past(isr_q[0])));
    a_r13_wake_covers_req: assert property (@(posedge clk) disable iff (rst)
        irq |-> wake);
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic            cfg_sel,
    input  logic [REGW-1:0] cfg_wdata,
    output logic [REGW-1:0] cfg_rdata,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [NTMR-1:0] tmr_ovf,
    input  logic            ser_rx_done,
    input  logic            ser_tx_done,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic            vec_take,
    input  logic            irq_return,
    output logic            irq_req,
    output logic [VECW-1:0] irq_vector,
    output logic [NSRC-1:0] src_ack,
    output logic [1:0]      isr_level,
    output logic            wake
);
    en_cfg_t         en;
    pri_cfg_t        pri;
    logic [NSRC-1:0] req;

    intc_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .en_o  (en),
        .pri_o (pri),
        .rdata (cfg_rdata)
    );

    intc_req u_req (
        .clk      (clk),
        .rst      (rst),
        .ext_n    (ext_n),
        .ext_edge (ext_edge),
        .tmr_ovf  (tmr_ovf),
        .ser_rx   (ser_rx_done),
        .ser_tx   (ser_tx_done),
        .t2_ovf   (t2_ovf),
        .t2_ext   (t2_ext),
        .taken    (src_ack),
        .req      (req)
    );

    intc_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .en      (en),
        .pri     (pri),
        .take    (vec_take),
        .ret     (irq_return),
        .irq     (irq_req),
        .vector  (irq_vector),
        .src_ack (src_ack),
        .isr     (isr_level),
        .wake    (wake)
    );

    a_r4_gate_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[TOP_BIT] && !cfg_sel |-> (!irq_req && !wake));
endmodule

// File: tb/intc_two_level_test.sv
module intc_two_level_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0, cfg_rdata;
    logic [1:0]  ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
    logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0, t2_ovf = 1'b0, t2_ext = 1'b0;
    logic        vec_take = 1'b0, irq_return = 1'b0;
    logic        irq_req, wake;
    logic [15:0] irq_vector;
    logic [5:0]  src_ack;
    logic [1:0]  isr_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intc_two_level uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_n(ext_n), .ext_edge(ext_edge), .tmr_ovf(tmr_ovf),
        .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
        .vec_take(vec_take), .irq_return(irq_return), .irq_req(irq_req),
        .irq_vector(irq_vector), .src_ack(src_ack), .isr_level(isr_level), .wake(wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic sel, input logic [7:0] exp);
        cfg_sel = sel;
        #1;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic take_check(input string tag, input logic [5:0] exp_ack);
        vec_take = 1'b1;
        #1;
        check(tag, 32'(src_ack), 32'(exp_ack));
        step(1);
        vec_take = 1'b0;
    endtask

    task automatic do_ret();
        irq_return = 1'b1;
        step(1);
        irq_return = 1'b0;
    endtask

    task automatic pulse_tmr(input int t);
        tmr_ovf[t] = 1'b1;
        step(1);
        tmr_ovf[t] = 1'b0;
    endtask

    function automatic logic [16:0] model(input logic [7:0] en, input logic [7:0] pr,
                                          input logic [5:0] rq);
        logic [5:0] live, hi, lo, sel;
        live = rq & en[5:0] & {6{en[7]}};
        hi   = live & (pr[7] ? 6'b0 : pr[5:0]);
        lo   = live & ~hi;
        sel  = (hi != 0) ? hi : lo;
        for (int i = 5; i >= 0; i--)
            if (sel[i]) model = {1'b1, 16'h0003 + 16'(i * 8)};
        if (sel == 0) model = '0;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd_check("R1 mask reset", 1'b0, 8'h40);
        rd_check("R1 level reset", 1'b1, 8'h40);
        check("R1 irq", 32'(irq_req), 0);
        check("R1 wake", 32'(wake), 0);
        check("R1 isr", 32'(isr_level), 0);

        // R4 gate off, R2 readback
        ser_rx_done = 1'b1;
        wr_reg(1'b0, 8'h3F);
        check("R4 gate off irq", 32'(irq_req), 0);
        check("R4 gate off wake", 32'(wake), 0);
        rd_check("R2 readback 3F", 1'b0, 8'h7F);
        wr_reg(1'b1, 8'h95);
        rd_check("R2 resv bit level", 1'b1, 8'hD5);
        wr_reg(1'b1, 8'h00);

        // R3 vector, R7 order, R8 level mode
        wr_reg(1'b0, 8'hBF);
        check("R3 serial vector", 32'(irq_vector), 32'h23);
        check("R4 gate on irq", 32'(irq_req), 1);
        t2_ovf = 1'b1;
        #1 check("R7 serial before t2", 32'(irq_vector), 32'h23);
        ext_n[0] = 1'b0;
        #1 check("R8 no combinational path", 32'(irq_vector), 32'h23);
        step(1);
        check("R8 level ext0 vector", 32'(irq_vector), 32'h03);
        ext_n[0] = 1'b1;
        step(1);
        check("R8 level not latched", 32'(irq_vector), 32'h23);
        wr_reg(1'b0, 8'hAF);
        check("R4 mask bit off serial", 32'(irq_vector), 32'h2B);
        wr_reg(1'b0, 8'hBF);

        // R5 / R6 levels
        wr_reg(1'b1, 8'h20);
        check("R5 high t2 wins", 32'(irq_vector), 32'h2B);
        wr_reg(1'b1, 8'hA0);
        check("R6 flat ignores level", 32'(irq_vector), 32'h23);
        wr_reg(1'b1, 8'h00);

        // R14 take, R11 blocking, R13 wake, R12 return, R10 sticky serial/t2
        ser_rx_done = 1'b0;
        #1 check("R3 t2 vector", 32'(irq_vector), 32'h2B);
        take_check("R14 ack t2", 6'h20);
        check("R11 isr low", 32'(isr_level), 1);
        check("R11 low blocks low", 32'(irq_req), 0);
        check("R13 wake while blocked", 32'(wake), 1);
        check("R14 no ack idle", 32'(src_ack), 0);
        wr_reg(1'b1, 8'h08);
        pulse_tmr(1);
        check("R11 high preempts", 32'(irq_vector), 32'h1B);
        take_check("R14 ack tmr1", 6'h08);
        check("R11 isr both", 32'(isr_level), 3);
        check("R11 high blocks all", 32'(irq_req), 0);
        do_ret();
        check("R12 return drops high", 32'(isr_level), 1);
        check("R10 tmr1 flag cleared", 32'(irq_req), 0);
        do_ret();
        check("R12 return drops low", 32'(isr_level), 0);
        check("R10 t2 not cleared", 32'(irq_vector), 32'h2B);

        // R6 no preemption in flat mode
        wr_reg(1'b1, 8'h88);
        take_check("R14 ack t2 flat", 6'h20);
        pulse_tmr(1);
        check("R6 flat no preempt", 32'(irq_req), 0);
        check("R6 isr low only", 32'(isr_level), 1);
        do_ret();
        check("R7 tmr1 before t2", 32'(irq_vector), 32'h1B);
        take_check("R14 ack tmr1 flat", 6'h08);
        do_ret();
        t2_ovf = 1'b0;
        #1 check("R10 all clear", 32'(irq_req), 0);
        wr_reg(1'b1, 8'h00);

        // R10 set and take in the same cycle
        pulse_tmr(0);
        check("R3 tmr0 vector", 32'(irq_vector), 32'h0B);
        tmr_ovf[0] = 1'b1;
        take_check("R14 ack tmr0", 6'h02);
        tmr_ovf[0] = 1'b0;
        do_ret();
        check("R10 set wins over take", 32'(irq_vector), 32'h0B);
        take_check("R14 ack tmr0 again", 6'h02);
        do_ret();
        check("R10 tmr0 cleared", 32'(irq_req), 0);

        // R9 edge latch
        ext_edge[1] = 1'b1;
        ext_n[1] = 1'b0;
        step(1);
        ext_n[1] = 1'b1;
        step(3);
        check("R9 edge latched", 32'(irq_vector), 32'h13);
        take_check("R9 ack ext1", 6'h04);
        check("R9 latch cleared", 32'(irq_req), 0);
        do_ret();
        ext_edge[1] = 1'b0;
        step(2);

        // random arbitration with level sources
        for (int it = 0; it < 300; it++) begin
            logic [7:0]  en, pr;
            logic [16:0] exp;
            logic [5:0]  rq;
            en = 8'($urandom); pr = 8'($urandom);
            ext_n = 2'($urandom);
            ser_rx_done = 1'($urandom); ser_tx_done = 1'($urandom);
            t2_ovf = 1'($urandom); t2_ext = 1'($urandom);
            wr_reg(1'b0, en);
            wr_reg(1'b1, pr);
            step(1);
            rq = {t2_ovf | t2_ext, ser_rx_done | ser_tx_done, 1'b0, ~ext_n[1], 1'b0, ~ext_n[0]};
            exp = model(en, pr, rq);
            check("R5 R6 R7 random irq", 32'(irq_req), 32'(exp[16]));
            check("R3 random vector", 32'(irq_vector), 32'(exp[15:0]));
            check("R13 random wake", 32'(wake), 32'((rq & en[5:0] & {6{en[7]}}) != 0));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule